// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits between a set of wakeup interrupt pins and a parent interrupt controller that accepts only two kinds of input: rising-edge events and active-high levels. Each pin has its own enable bit and a 3-bit trigger-type field. Using these, the block converts falling edges, active-low levels and transitions in both directions into the positive sense that the parent understands.

Every pin passes through a two-flop synchronizer before any detection. An edge-type pin produces a pulse on its output that lasts one clock. A level-type pin drives its output with the synchronized input after any inversion it needs. Software reaches the enable words and the per-pin type words over a simple 32-bit word-addressed register bus. A read returns its data one clock after the request.

Top module: `irq_sense_norm`

## Requirements
- R1: After reset every `irq_o` bit is 0, and every enable word and type word reads 0.
- R2: The enable words start at word address 4 (byte 0x10). Pin n is controlled by bit n%32 of word 4+n/32, and a 1 in that bit enables the pin. The bits read back as they were written.
- R3: The type word of pin n is at word address 68+n (byte 0x110+4n). Only `wdata_i[2:0]` is stored. A read of a type word returns the stored 3 bits with bits 31:3 equal to 0.
- R4: With type 100 (active-high level), the output follows the input. An input change that the first synchronizer flop captures at edge k reaches `irq_o` after edge k+2.
- R5: With type 000 (active-low level), the output is the inverted input, with the same latency as R4.
- R6: With type 110 (rising edge), each low-to-high transition of the input gives a one-cycle high pulse. The latency is the same as R4.
- R7: With type 010 (falling edge), each high-to-low transition gives a one-cycle high pulse.
- R8: With type 111 (both edges), every transition in either direction gives a one-cycle high pulse.
- R9: A pin whose enable bit is 0 holds its output at 0, whatever its input and type.
- R10: The undefined types 001, 011 and 101 hold the pin's output at 0.
- R11: A write to an enable word or a type word changes `irq_o` after the second clock edge that follows the write. A write alone, with a steady input, never produces an edge pulse.
- R12: In the last enable word, bits for pin numbers at or above NUM_PINS read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Asynchronous interrupt inputs |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after a read request |
| irq_o | output | NUM_PINS | Positive-sense outputs to the parent controller |

## Verification
The bench builds the block with NUM_PINS = 40. This makes the second enable word partial: only its low eight bits are real. That brings the R12 tail masking and the R2 bank split within reach of a short run. With 40 pins, each trigger type, each undefined code and the enable gate can be placed on a separate pin and checked cycle by cycle. The last type word (pin 39) is also used, to check the upper end of the type-word range.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned TYPE_W   = 3;
  localparam int unsigned EN_WORD  = 32'h10 >> 2;
  localparam int unsigned CFG_WORD = 32'h110 >> 2;

  typedef enum logic [TYPE_W-1:0] {
    TRIG_LVL_LO = 3'b000,
    TRIG_FALL   = 3'b010,
    TRIG_LVL_HI = 3'b100,
    TRIG_RISE   = 3'b110,
    TRIG_BOTH   = 3'b111
  } trig_e;
endpackage

// File: rtl/irq_sense_sync.sv
module irq_sense_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
  import irq_sense_pkg::*;
#(
  parameter int unsigned NUM_PINS = 126,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [BUS_W-1:0]                 wdata_i,
  output logic [BUS_W-1:0]                 rdata_o,
  output logic [NUM_PINS-1:0]              en_o,
  output logic [NUM_PINS-1:0][TYPE_W-1:0]  cfg_o
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + BUS_W - 1) / BUS_W;
  localparam int unsigned TAIL_BITS = NUM_PINS - BUS_W * (NUM_BANKS - 1);
  localparam logic [BUS_W-1:0] TAIL_MASK =
    (TAIL_BITS == BUS_W) ? '1 : ((BUS_W'(1) << TAIL_BITS) - BUS_W'(1));

  logic                            wr;
  logic [NUM_PINS-1:0]             en_q;
  logic [NUM_PINS-1:0][TYPE_W-1:0] cfg_q;
  logic [BUS_W-1:0]                rd_mux, rdata_q;
  logic                            cfg_hit;

  assign wr      = req_i & we_i;
  assign cfg_hit = (addr_i >= ADDR_W'(CFG_WORD)) && (addr_i < ADDR_W'(CFG_WORD + NUM_PINS));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int unsigned BANK = EN_WORD + i / BUS_W;
    localparam int unsigned BIT  = i % BUS_W;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[i] <= 1'b0;
      else if (wr && addr_i == ADDR_W'(BANK)) en_q[i] <= wdata_i[BIT];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[i] <= '0;
      else if (wr && addr_i == ADDR_W'(CFG_WORD + i)) cfg_q[i] <= wdata_i[TYPE_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr_i == ADDR_W'(EN_WORD + i / BUS_W)) rd_mux[i % BUS_W] = en_q[i];
      if (addr_i == ADDR_W'(CFG_WORD + i))        rd_mux[TYPE_W-1:0] = cfg_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign cfg_o   = cfg_q;

  // R3: type word reads are 3 bits wide
  a_r3_cfg_read_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && cfg_hit) |=> (rdata_o[BUS_W-1:TYPE_W] == '0));

  // R12: absent pins in the last enable word read as zero
  a_r12_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(EN_WORD + NUM_BANKS - 1))
      |=> ((rdata_o & ~TAIL_MASK) == '0));
endmodule

// File: rtl/irq_sense_cell.sv
module irq_sense_cell
  import irq_sense_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cur_i,
  input  logic              en_i,
  input  logic [TYPE_W-1:0] cfg_i,
  output logic              irq_o
);
  logic prev_q, irq_q, sense;

  always_comb begin
    unique case (cfg_i)
      TRIG_LVL_LO: sense = ~cur_i;
      TRIG_LVL_HI: sense = cur_i;
      TRIG_RISE:   sense = cur_i & ~prev_q;
      TRIG_FALL:   sense = ~cur_i & prev_q;
      TRIG_BOTH:   sense = cur_i ^ prev_q;
      default:     sense = 1'b0;
    endcase
  end

  // prev tracks the input regardless of type, so a type write cannot fake an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= cur_i;
      irq_q  <= en_i & sense;
    end
  end

  assign irq_o = irq_q;

  // R9: a disabled pin stays quiet
  a_r9_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);

  // R6: rising-edge pulses last one cycle
  a_r6_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && cfg_i == TRIG_RISE && $stable(cfg_i)) |=> (!irq_o || cfg_i != $past(cfg_i)));

  // R10: undefined codes stay quiet
  a_r10_undef_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == 3'b001 || cfg_i == 3'b011 || cfg_i == 3'b101) |=> !irq_o);
endmodule

// File: rtl/irq_sense_norm.sv
module irq_sense_norm
  import irq_sense_pkg::*;
#(
  parameter int unsigned NUM_PINS = 126,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  output logic [NUM_PINS-1:0] irq_o
);
  logic [NUM_PINS-1:0]             pin_sync;
  logic [NUM_PINS-1:0]             en;
  logic [NUM_PINS-1:0][TYPE_W-1:0] cfg;

  irq_sense_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  irq_sense_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en),
    .cfg_o   (cfg)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
    irq_sense_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cur_i  (pin_sync[i]),
      .en_i   (en[i]),
      .cfg_i  (cfg[i]),
      .irq_o  (irq_o[i])
    );
  end
endmodule

// File: tb/irq_sense_norm_tb.sv
module irq_sense_norm_tb_top;
  localparam int unsigned NP = 40;
  localparam int unsigned AW = 8;

  typedef struct {
    int          when;
    int          pin;
    logic        val;
    logic [NP-1:0] vec;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] irq;

  int   cyc = 0, total = 0, bad = 0;
  bit   done = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  irq_sense_norm #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compare due scoreboard items each cycle
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      for (int k = sb.size() - 1; k >= 0; k--) begin
        if (sb[k].when <= cyc) begin
          total++;
          if (sb[k].when < cyc) begin
            bad++;
            $display("FAIL %s: item for cycle %0d missed", sb[k].tag, sb[k].when);
          end else if (sb[k].pin < 0) begin
            if (irq !== sb[k].vec) begin
              bad++;
              $display("FAIL %s: irq=%h expected %h", sb[k].tag, irq, sb[k].vec);
            end
          end else if (irq[sb[k].pin] !== sb[k].val) begin
            bad++;
            $display("FAIL %s: pin %0d irq=%b expected %b", sb[k].tag, sb[k].pin,
                     irq[sb[k].pin], sb[k].val);
          end
          sb.delete(k);
        end
      end
    end
  end

  task automatic push_pin(int p, logic v, int dly, string tag);
    exp_t e;
    e.when = cyc + dly; e.pin = p; e.val = v; e.vec = '0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic push_vec(logic [NP-1:0] v, int dly, string tag);
    exp_t e;
    e.when = cyc + dly; e.pin = -1; e.val = 1'b0; e.vec = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(posedge clk);
    #2;
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s: read word %0d got %h expected %h", tag, a, rdata, exp);
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  // drive a pin; edge/level effect lands 3 samples later
  task automatic set_pin(int p, logic v);
    @(negedge clk);
    pin[p] = v;
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    total++;
    if (irq !== '0) begin
      bad++; $display("FAIL R1: irq=%h expected 0", irq);
    end
    bus_read(4, 32'h0, "R1");
    bus_read(68, 32'h0, "R1");

    // R9: types reset to active-low, pins low, but disabled -> quiet
    push_vec('0, 2, "R9");
    idle(3);

    // R2/R12: enable everything
    bus_write(4, 32'hFFFF_FFFF);
    bus_write(5, 32'hFFFF_FFFF);
    push_vec('1, 1, "R5");
    bus_read(4, 32'hFFFF_FFFF, "R2");
    bus_read(5, 32'h0000_00FF, "R12");

    // R3 + R4: active-high level on pin 0
    bus_write(68, 32'hFFFF_FFFC);
    push_pin(0, 1'b0, 1, "R11");
    bus_read(68, 32'h4, "R3");
    set_pin(0, 1'b1);
    push_pin(0, 1'b0, 2, "R4");
    push_pin(0, 1'b1, 3, "R4");
    push_pin(0, 1'b1, 5, "R4");
    idle(6);
    set_pin(0, 1'b0);
    push_pin(0, 1'b0, 3, "R4");
    idle(5);

    // R5: active-low level on pin 1
    set_pin(1, 1'b1);
    push_pin(1, 1'b1, 2, "R5");
    push_pin(1, 1'b0, 3, "R5");
    idle(5);

    // R6 + R11: rising edge on pin 2
    bus_write(70, 32'h6);
    push_pin(2, 1'b0, 1, "R11");
    push_pin(2, 1'b0, 2, "R11");
    idle(3);
    set_pin(2, 1'b1);
    push_pin(2, 1'b0, 2, "R6");
    push_pin(2, 1'b1, 3, "R6");
    push_pin(2, 1'b0, 4, "R6");
    push_pin(2, 1'b0, 5, "R6");
    idle(6);
    set_pin(2, 1'b0);
    push_pin(2, 1'b0, 3, "R6");
    push_pin(2, 1'b0, 4, "R6");
    idle(6);

    // R7 + R11: falling edge on pin 3, type written while input high
    set_pin(3, 1'b1);
    idle(5);
    bus_write(71, 32'h2);
    push_pin(3, 1'b0, 1, "R11");
    push_pin(3, 1'b0, 2, "R11");
    push_pin(3, 1'b0, 3, "R11");
    idle(4);
    set_pin(3, 1'b0);
    push_pin(3, 1'b0, 2, "R7");
    push_pin(3, 1'b1, 3, "R7");
    push_pin(3, 1'b0, 4, "R7");
    idle(6);

    // R8: both edges on pin 4
    bus_write(72, 32'h7);
    idle(3);
    set_pin(4, 1'b1);
    push_pin(4, 1'b1, 3, "R8");
    push_pin(4, 1'b0, 4, "R8");
    idle(6);
    set_pin(4, 1'b0);
    push_pin(4, 1'b1, 3, "R8");
    push_pin(4, 1'b0, 4, "R8");
    idle(6);

    // R10: undefined codes on pins 5..7, one input high
    bus_write(73, 32'h1);
    bus_write(74, 32'h3);
    bus_write(75, 32'h5);
    set_pin(6, 1'b1);
    push_pin(5, 1'b0, 1, "R10");
    push_pin(5, 1'b0, 4, "R10");
    push_pin(6, 1'b0, 4, "R10");
    push_pin(7, 1'b0, 4, "R10");
    idle(6);

    // R9: disable pin 2 (rising), then give it an edge
    bus_write(4, 32'hFFFF_FFFB);
    set_pin(2, 1'b1);
    push_pin(2, 1'b0, 3, "R9");
    push_pin(2, 1'b0, 4, "R9");
    push_pin(0, 1'b0, 3, "R9");
    idle(6);
    bus_read(4, 32'hFFFF_FFFB, "R2");

    // R3: last type word, upper data bits dropped
    bus_write(68 + 39, 32'hFFFF_FFFF);
    bus_read(68 + 39, 32'h7, "R3");

    // R12: clearing the partial word
    bus_write(5, 32'h0);
    bus_read(5, 32'h0, "R12");
    push_pin(39, 1'b0, 1, "R12");
    idle(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule